// File: doc/BRIEF.md
# Two-Level Programmable Interrupt Router

This block gathers up to 64 single-bit event lines from peripherals and delivers them to a set of host interrupt outputs. Each event has a sticky status bit and an enable bit. An event that is both latched and enabled is pending. Each pending event passes through two programmable lookup stages. The first stage assigns each event to one of ten interrupt channels. The second stage assigns each channel to one of ten hosts. Both stages are many-to-one. Any host may therefore collect anywhere from none to all of the events, and the block ORs them together.

Hosts 0 and 1 drive a small core-facing output vector. Hosts 2 to 9 drive eight lines that are wired one-to-one into an external interrupt controller. Every host also has a readable priority word. It names the winning pending event: the lowest-numbered channel wins first, then the lowest-numbered event within that channel. A flag in the word marks when nothing is pending. Software sets up maps, enables and clears through a plain synchronous address/data port. Read data comes back one cycle after the address.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high and after it falls, all host outputs and `reg_rdata` are 0. All status bits, event enables, host enables, the global enable and both map tables are 0. Every priority word reads 0x8000_0000.
- R2: A 0-to-1 change on `evt_i[e]` sets status bit e one clock edge after it is sampled. The bit stays set after the input falls, and a level held high does not set it again.
- R3: Writing the word at 0x08+w clears each status bit of events 32w..32w+31 whose data bit is 1. Zero bits leave their status bit unchanged. Writing an index to 0x06 clears that single status bit. A rising edge in the same cycle as a clear leaves the bit set.
- R4: The word at 0x0C+w reads and writes the enables of events 32w..32w+31. Writing an index to 0x04 sets that single enable and writing it to 0x05 clears it. Other enables are unchanged. A latched event whose enable is 0 reaches no output and no priority word.
- R5: The event map entry at 0x40+e (4 bits) selects a channel, and the channel map entry at 0x10+c (4 bits) selects a host. A pending event raises its host's output two edges after its input edge is sampled. A selector value of 10 or more routes nowhere.
- R6: A host output stays high while at least one pending event reaches it, however many events share it. It falls only once the last of them is cleared or disabled.
- R7: A host output is also gated by its bit in the host-enable word at 0x01 and by bit 0 of the control word at 0x00. Neither gate changes the priority words.
- R8: The priority word of host h is read at 0x20+h. Bit 31 is 1 when no pending event reaches host h, and bits 5:0 then read 0. Otherwise bits 5:0 hold the event in the lowest-numbered channel that is mapped to h and has a pending event, taking the lowest event number within that channel.
- R9: `reg_rdata` presents, one edge after `reg_addr` is sampled, the register at that address. Both map tables read back what was written. Unused addresses and the index registers read 0.
- R10: `core_irq_o[i]` carries host i for i in 0..1, and `ext_irq_o[j]` carries host j+2 for j in 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 64 | Peripheral event lines |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Registered read data |
| core_irq_o | output | 2 | Host outputs 0..1 toward the local cores |
| ext_irq_o | output | 8 | Host outputs 2..9 toward the external controller |

## Verification
A status bit is set on the first edge after an input rises. The host output and its priority word follow on the second edge. Read data follows its address by one edge. The bench changes inputs on falling edges and samples on falling edges, and it waits two of them after an event edge before it checks the outputs. It always places an output check between a stimulus or clearing write and any read of a priority word, so that the read sees the settled value and not the one from the previous cycle. The mid-run reset, the simultaneous rise-and-clear and the unroutable selector are checked as directed steps after the vector walk.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] A_HOSTEN  = 8'h01;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 8'h04;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 8'h05;
  localparam logic [ADDR_W-1:0] A_ST_CLR  = 8'h06;
  localparam logic [ADDR_W-1:0] A_ST_BASE = 8'h08;
  localparam logic [ADDR_W-1:0] A_EN_BASE = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CHMAP   = 8'h10;
  localparam logic [ADDR_W-1:0] A_PRIO    = 8'h20;
  localparam logic [ADDR_W-1:0] A_EVMAP   = 8'h40;
endpackage

// File: rtl/irq_evt_regs.sv
module irq_evt_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_EVT-1:0] status_o,
  output logic [NUM_EVT-1:0] enable_o
);
  localparam int NUM_WORDS = (NUM_EVT + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;
  localparam int IDX_W     = $clog2(NUM_EVT);

  logic [NUM_EVT-1:0] evt_q, status_q, enable_q, status_n, enable_n;
  logic [NUM_EVT-1:0] rise, one_hot;
  logic [PAD_W-1:0]   wide_clr, wide_sel, wide_val;
  logic               idx_ok;

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      assign wide_clr[w*DATA_W +: DATA_W] =
        (we && addr == A_ST_BASE + ADDR_W'(w)) ? wdata : '0;
      assign wide_sel[w*DATA_W +: DATA_W] =
        {DATA_W{we && addr == A_EN_BASE + ADDR_W'(w)}};
      assign wide_val[w*DATA_W +: DATA_W] = wdata;
    end
  endgenerate

  assign rise    = evt_i & ~evt_q;
  assign idx_ok  = wdata < DATA_W'(NUM_EVT);
  assign one_hot = NUM_EVT'(1) << wdata[IDX_W-1:0];

  always_comb begin
    logic [NUM_EVT-1:0] clr;
    clr = wide_clr[NUM_EVT-1:0];
    if (we && idx_ok && addr == A_ST_CLR) clr = clr | one_hot;
    // a fresh edge outranks a clear in the same cycle
    status_n = (status_q & ~clr) | rise;

    enable_n = (enable_q & ~wide_sel[NUM_EVT-1:0]) |
               (wide_val[NUM_EVT-1:0] & wide_sel[NUM_EVT-1:0]);
    if (we && idx_ok && addr == A_EN_SET) enable_n = enable_n | one_hot;
    if (we && idx_ok && addr == A_EN_CLR) enable_n = enable_n & ~one_hot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q    <= '0;
      status_q <= '0;
      enable_q <= '0;
    end else begin
      evt_q    <= evt_i;
      status_q <= status_n;
      enable_q <= enable_n;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CH   = 10,
  parameter int NUM_HOST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [((NUM_CH+1) > (NUM_HOST+1) ? $clog2(NUM_CH+1) : $clog2(NUM_HOST+1))-1:0] wdata,
  output logic [$clog2(NUM_CH+1)-1:0]   ev_ch_o   [NUM_EVT],
  output logic [$clog2(NUM_HOST+1)-1:0] ch_host_o [NUM_CH]
);
  localparam int CSEL_W = $clog2(NUM_CH + 1);
  localparam int HSEL_W = $clog2(NUM_HOST + 1);

  genvar e, c;
  generate
    for (e = 0; e < NUM_EVT; e++) begin : g_ev
      always_ff @(posedge clk) begin
        if (rst) ev_ch_o[e] <= '0;
        else if (we && addr == A_EVMAP + ADDR_W'(e)) ev_ch_o[e] <= wdata[CSEL_W-1:0];
      end
    end
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) ch_host_o[c] <= '0;
        else if (we && addr == A_CHMAP + ADDR_W'(c)) ch_host_o[c] <= wdata[HSEL_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CH   = 10,
  parameter int NUM_HOST = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_EVT-1:0]            pend,
  input  logic [$clog2(NUM_CH+1)-1:0]   ev_ch   [NUM_EVT],
  input  logic [$clog2(NUM_HOST+1)-1:0] ch_host [NUM_CH],
  input  logic                          glb_en,
  input  logic [NUM_HOST-1:0]           host_en,
  output logic [NUM_HOST-1:0]           host_irq_o,
  output logic [NUM_HOST-1:0]           prio_none_o,
  output logic [$clog2(NUM_EVT)-1:0]    prio_idx_o [NUM_HOST]
);
  localparam int CSEL_W = $clog2(NUM_CH + 1);
  localparam int HSEL_W = $clog2(NUM_HOST + 1);
  localparam int EVT_IW = $clog2(NUM_EVT);

  logic [NUM_CH-1:0]   ch_any;
  logic [EVT_IW-1:0]   ch_evt   [NUM_CH];
  logic [NUM_HOST-1:0] host_any;
  logic [EVT_IW-1:0]   host_evt [NUM_HOST];

  genvar c, h;
  generate
    // stage one: lowest pending event per channel
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
        ch_any[c] = 1'b0;
        ch_evt[c] = '0;
        for (int e = NUM_EVT - 1; e >= 0; e--) begin
          if (pend[e] && ev_ch[e] == CSEL_W'(c)) begin
            ch_any[c] = 1'b1;
            ch_evt[c] = EVT_IW'(e);
          end
        end
      end
    end
    // stage two: lowest active channel per host
    for (h = 0; h < NUM_HOST; h++) begin : g_host
      always_comb begin
        host_any[h] = 1'b0;
        host_evt[h] = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
          if (ch_any[k] && ch_host[k] == HSEL_W'(h)) begin
            host_any[h] = 1'b1;
            host_evt[h] = ch_evt[k];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          host_irq_o[h]  <= 1'b0;
          prio_none_o[h] <= 1'b1;
          prio_idx_o[h]  <= '0;
        end else begin
          host_irq_o[h]  <= host_any[h] & host_en[h] & glb_en;
          prio_none_o[h] <= ~host_any[h];
          prio_idx_o[h]  <= host_evt[h];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CH   = 10,
  parameter int NUM_HOST = 10,
  parameter int NUM_CORE = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_EVT-1:0]       evt_i,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic                     reg_we,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic [NUM_CORE-1:0]      core_irq_o,
  output logic [NUM_HOST-NUM_CORE-1:0] ext_irq_o
);
  localparam int CSEL_W    = $clog2(NUM_CH + 1);
  localparam int HSEL_W    = $clog2(NUM_HOST + 1);
  localparam int MAP_W     = (CSEL_W > HSEL_W) ? CSEL_W : HSEL_W;
  localparam int EVT_IW    = $clog2(NUM_EVT);
  localparam int NUM_WORDS = (NUM_EVT + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;

  logic                 glb_en_q;
  logic [NUM_HOST-1:0]  host_en_q;
  logic [NUM_EVT-1:0]   evt_status, evt_enable;
  logic [CSEL_W-1:0]    ev_ch   [NUM_EVT];
  logic [HSEL_W-1:0]    ch_host [NUM_CH];
  logic [NUM_HOST-1:0]  host_irq, prio_none;
  logic [EVT_IW-1:0]    prio_idx [NUM_HOST];
  logic [PAD_W-1:0]     stat_pad, en_pad;
  logic [DATA_W-1:0]    rd_n, rdata_q;

  irq_evt_regs #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .status_o (evt_status),
    .enable_o (evt_enable)
  );

  irq_map_regs #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)) u_map (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata[MAP_W-1:0]),
    .ev_ch_o   (ev_ch),
    .ch_host_o (ch_host)
  );

  irq_resolve #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)) u_res (
    .clk         (clk),
    .rst         (rst),
    .pend        (evt_status & evt_enable),
    .ev_ch       (ev_ch),
    .ch_host     (ch_host),
    .glb_en      (glb_en_q),
    .host_en     (host_en_q),
    .host_irq_o  (host_irq),
    .prio_none_o (prio_none),
    .prio_idx_o  (prio_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en_q  <= 1'b0;
      host_en_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CTRL)   glb_en_q  <= reg_wdata[0];
      if (reg_addr == A_HOSTEN) host_en_q <= reg_wdata[NUM_HOST-1:0];
    end
  end

  assign stat_pad = PAD_W'(evt_status);
  assign en_pad   = PAD_W'(evt_enable);

  always_comb begin
    rd_n = '0;
    if (reg_addr == A_CTRL)   rd_n = DATA_W'(glb_en_q);
    if (reg_addr == A_HOSTEN) rd_n = DATA_W'(host_en_q);
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr == A_ST_BASE + ADDR_W'(w)) rd_n = stat_pad[w*DATA_W +: DATA_W];
      if (reg_addr == A_EN_BASE + ADDR_W'(w)) rd_n = en_pad[w*DATA_W +: DATA_W];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == A_CHMAP + ADDR_W'(c)) rd_n = DATA_W'(ch_host[c]);
    end
    for (int h = 0; h < NUM_HOST; h++) begin
      if (reg_addr == A_PRIO + ADDR_W'(h)) begin
        rd_n = DATA_W'(prio_idx[h]);
        rd_n[DATA_W-1] = prio_none[h];
      end
    end
    for (int e = 0; e < NUM_EVT; e++) begin
      if (reg_addr == A_EVMAP + ADDR_W'(e)) rd_n = DATA_W'(ev_ch[e]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_n;
  end

  assign reg_rdata  = rdata_q;
  assign core_irq_o = host_irq[NUM_CORE-1:0];
  assign ext_irq_o  = host_irq[NUM_HOST-1:NUM_CORE];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_EVT  = 64,
  parameter int NUM_HOST = 10
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_EVT-1:0]  evt_i,
  input logic                reg_we,
  input logic [NUM_EVT-1:0]  status,
  input logic [NUM_EVT-1:0]  enable,
  input logic                glb_en,
  input logic [NUM_HOST-1:0] irq
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq == '0 && status == '0)); // R1

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(evt_i) & ~$past(evt_i, 2)) & ~status) == '0)); // R2

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status) & ~status) == '0) || $past(reg_we))); // R3

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) == '0) |=> (irq == '0)); // R5

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> (irq == '0)); // R7
endmodule

bind irq_router irq_router_chk #(.NUM_EVT(NUM_EVT), .NUM_HOST(NUM_HOST)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .evt_i  (evt_i),
  .reg_we (reg_we),
  .status (evt_status),
  .enable (evt_enable),
  .glb_en (glb_en_q),
  .irq    (host_irq)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] evt = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [1:0]  core_irq;
  logic [7:0]  ext_irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_router u_dut (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .core_irq_o (core_irq),
    .ext_irq_o  (ext_irq)
  );

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_EVL = 3'd2, OP_EVH = 3'd3, OP_IRQ = 3'd4;
  localparam int NV = 53;
  // {req, op, addr, data, expected}
  localparam logic [78:0] VEC [NV] = '{
    {4'd7, OP_WR,  8'h00, 32'h1,   32'h0},        // R7 global on
    {4'd7, OP_WR,  8'h01, 32'h3FF, 32'h0},        // R7 hosts on
    {4'd5, OP_WR,  8'h45, 32'h3,   32'h0},        // R5 evt5 -> ch3
    {4'd5, OP_WR,  8'h13, 32'h4,   32'h0},        // R5 ch3 -> host4
    {4'd9, OP_RD,  8'h45, 32'h0,   32'h3},        // R9 map readback
    {4'd9, OP_RD,  8'h13, 32'h0,   32'h4},        // R9
    {4'd4, OP_WR,  8'h04, 32'h5,   32'h0},        // R4 set enable by index
    {4'd4, OP_RD,  8'h0C, 32'h0,   32'h20},       // R4
    {4'd2, OP_EVL, 8'h00, 32'h20,  32'h0},        // R2 evt5 rises
    {4'd5, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R5 host4
    {4'd8, OP_RD,  8'h24, 32'h0,   32'h5},        // R8
    {4'd2, OP_RD,  8'h08, 32'h0,   32'h20},       // R2 status
    {4'd2, OP_EVL, 8'h00, 32'h0,   32'h0},        // R2 input falls
    {4'd2, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R2 sticky
    {4'd3, OP_WR,  8'h08, 32'h20,  32'h0},        // R3 word clear
    {4'd3, OP_IRQ, 8'h00, 32'h0,   32'h000},      // R3
    {4'd8, OP_RD,  8'h24, 32'h0,   32'h80000000}, // R8 none
    {4'd6, OP_WR,  8'h68, 32'h3,   32'h0},        // R6 evt40 -> ch3
    {4'd6, OP_WR,  8'h47, 32'h2,   32'h0},        // R6 evt7 -> ch2
    {4'd6, OP_WR,  8'h12, 32'h4,   32'h0},        // R6 ch2 -> host4
    {4'd4, OP_WR,  8'h0D, 32'h100, 32'h0},        // R4 word enable evt40
    {4'd4, OP_WR,  8'h04, 32'h7,   32'h0},        // R4
    {4'd4, OP_RD,  8'h0C, 32'h0,   32'hA0},       // R4
    {4'd6, OP_EVH, 8'h00, 32'h100, 32'h0},        // R6 evt40 rises
    {4'd6, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R6
    {4'd8, OP_RD,  8'h24, 32'h0,   32'h28},       // R8
    {4'd6, OP_EVL, 8'h00, 32'h80,  32'h0},        // R6 evt7 rises
    {4'd6, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R6
    {4'd8, OP_RD,  8'h24, 32'h0,   32'h7},        // R8 lower channel wins
    {4'd3, OP_WR,  8'h06, 32'h7,   32'h0},        // R3 index clear
    {4'd6, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R6 still one left
    {4'd8, OP_RD,  8'h24, 32'h0,   32'h28},       // R8
    {4'd8, OP_EVL, 8'h00, 32'hA0,  32'h0},        // R8 evt5 rises again
    {4'd8, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R8
    {4'd8, OP_RD,  8'h24, 32'h0,   32'h5},        // R8 lower event wins
    {4'd7, OP_WR,  8'h01, 32'h3EF, 32'h0},        // R7 host4 off
    {4'd7, OP_IRQ, 8'h00, 32'h0,   32'h000},      // R7
    {4'd7, OP_RD,  8'h24, 32'h0,   32'h5},        // R7 priority kept
    {4'd7, OP_WR,  8'h01, 32'h3FF, 32'h0},        // R7
    {4'd7, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R7
    {4'd7, OP_WR,  8'h00, 32'h0,   32'h0},        // R7 global off
    {4'd7, OP_IRQ, 8'h00, 32'h0,   32'h000},      // R7
    {4'd7, OP_WR,  8'h00, 32'h1,   32'h0},        // R7
    {4'd7, OP_IRQ, 8'h00, 32'h0,   32'h010},      // R7
    {4'd2, OP_RD,  8'h09, 32'h0,   32'h100},      // R2 upper status word
    {4'd4, OP_WR,  8'h05, 32'h5,   32'h0},        // R4 clear enable by index
    {4'd3, OP_WR,  8'h09, 32'h100, 32'h0},        // R3 upper word clear
    {4'd4, OP_IRQ, 8'h00, 32'h0,   32'h000},      // R4 disabled latch ignored
    {4'd4, OP_RD,  8'h24, 32'h0,   32'h80000000}, // R4
    {4'd10, OP_WR, 8'h04, 32'h0,   32'h0},        // R10 enable evt0
    {4'd10, OP_EVL, 8'h00, 32'hA1, 32'h0},        // R10 evt0 rises
    {4'd10, OP_IRQ, 8'h00, 32'h0,  32'h001},      // R10 core line 0
    {4'd8, OP_RD,  8'h20, 32'h0,   32'h0}         // R8 host0 -> evt0
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req, input string what);
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata, exp, req, what);
  endtask

  task automatic irq(input logic [31:0] exp, input int req, input string what);
    @(negedge clk);
    check(32'({ext_irq, core_irq}), exp, req, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(32'({ext_irq, core_irq}), 32'h0, 1, "outputs in reset");   // R1
    rst = 1'b0;
    @(negedge clk);
    check(reg_rdata, 32'h0, 1, "rdata after reset");                // R1
    rd(8'h24, 32'h80000000, 1, "prio after reset");                 // R1
    rd(8'h08, 32'h0, 1, "status after reset");                      // R1

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  req;
      logic [2:0]  op;
      logic [7:0]  a;
      logic [31:0] d, x;
      {req, op, a, d, x} = VEC[i];
      case (op)
        OP_WR:  wr(a, d);
        OP_RD:  rd(a, x, int'(req), $sformatf("vector %0d read", i));
        OP_EVL: begin evt[31:0]  = d; @(negedge clk); end
        OP_EVH: begin evt[63:32] = d; @(negedge clk); end
        default: irq(x, int'(req), $sformatf("vector %0d outputs", i));
      endcase
    end

    // R1: reset mid-run clears outputs, enables and maps
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(32'({ext_irq, core_irq}), 32'h0, 1, "outputs under reset");
    rst = 1'b0;
    evt = '0;
    @(negedge clk);
    rd(8'h0C, 32'h0, 1, "enables after reset");
    rd(8'h45, 32'h0, 1, "event map after reset");
    rd(8'h00, 32'h0, 1, "control after reset");

    // R3: rising edge in the same cycle as its clear keeps the bit
    wr(8'h00, 32'h1);
    wr(8'h01, 32'h3FF);
    wr(8'h04, 32'd9);
    evt[9] = 1'b1;
    wr(8'h08, 32'h200);
    irq(32'h001, 3, "set beats clear");
    rd(8'h08, 32'h200, 3, "status after set/clear race");

    // R5: selector beyond the channel range routes nowhere
    wr(8'h49, 32'hF);
    irq(32'h000, 5, "unroutable event");
    rd(8'h20, 32'h80000000, 5, "prio with unroutable event");
    rd(8'h08, 32'h200, 5, "status kept while unroutable");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule